// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block caches translations from virtual page numbers to physical frame numbers in a fully associative array. Each cached translation carries a context identifier that names the owning address space. The same virtual page can therefore be held for several processes at once, each with its own frame. A lookup port gives hit, frame and flags in the same cycle as the request. After a miss has been resolved elsewhere, a fill port stores the new translation. The page walk is outside this block.

A root-register write is passed in as a one-cycle event. When context tagging is off, this event empties the whole buffer. When tagging is on, it changes nothing, because stale entries are told apart by their identifier. A separate operation drops every entry that belongs to one named context.

Top module: `ctx_tlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every lookup misses.
- R2: A lookup is answered combinationally in the cycle of the request. On a hit, `lk_pfn` and `lk_flags` carry the stored frame and flags. On a miss, `lk_hit` is 0 and both fields read zero. A fill becomes visible to lookups from the next cycle on.
- R3: With `tag_en` = 1, a hit needs both the page number and the context identifier to match.
- R4: With `tag_en` = 1, entries that have the same page number but different identifiers coexist, and each resolves to its own frame.
- R5: With `tag_en` = 0, a hit needs only the page number to match. When several entries match, the one with the lowest index answers.
- R6: A `root_wr` pulse with `tag_en` = 0 invalidates every entry. With `tag_en` = 1, the pulse leaves every entry untouched.
- R7: A fill goes to the lowest-index invalid entry. When no entry is free, it replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping at the depth, after each such replacement only.
- R8: A fill whose key matches a valid entry, under the same rule a lookup uses, overwrites that entry in place. It does not take a new slot and does not move the pointer.
- R9: A `ctx_kill` pulse invalidates every entry whose identifier equals `kill_ctx`. All other entries are left as they are.
- R10: When an invalidation (`ctx_kill`, or a flushing `root_wr`) arrives in the same cycle as `fl_valid`, the fill is discarded.
- R11: The depth is a parameter of at least 2, with a nominal value of 1024 entries. The page number is 36 bits, the frame 40 bits, the flags 8 bits and the identifier 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tag_en | input | 1 | Context tagging enabled |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_ctx | input | 12 | Lookup context identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 40 | Frame number on hit, else zero |
| lk_flags | output | 8 | Flags on hit, else zero |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 36 | Fill virtual page number |
| fl_ctx | input | 12 | Fill context identifier |
| fl_pfn | input | 40 | Fill frame number |
| fl_flags | input | 8 | Fill flags |
| root_wr | input | 1 | Root-register write event |
| ctx_kill | input | 1 | Invalidate by context |
| kill_ctx | input | 12 | Context identifier to invalidate |

## Verification
The bench runs lookups that differ in only one field of the key: page number alone, then identifier alone. It also pairs a page held under two identifiers, which separates the tagged match from the page-only match and shows the lowest-index rule when tagging is turned off. Root writes are tried in both tagging modes, and a context kill is applied to a mixed population. Each kind of invalidation is also placed in the same cycle as a fill. A four-entry instance is filled past capacity, and an in-place overwrite is placed between two evictions, so a pointer that moves on an overwrite shows up as the wrong surviving entry.

// File: rtl/ctx_tlb_pkg.sv
// Shared widths and the fill-target selector type for the context-tagged TLB.
package ctx_tlb_pkg;
    localparam int VPN_W_DEF = 36;
    localparam int PFN_W_DEF = 40;
    localparam int FLG_W_DEF = 8;
    localparam int CTX_W_DEF = 12;

    // Where a fill lands: matching entry, free entry, or round-robin victim.
    typedef enum logic [1:0] {
        FILL_NONE  = 2'd0,
        FILL_HIT   = 2'd1,
        FILL_FREE  = 2'd2,
        FILL_EVICT = 2'd3
    } fill_src_e;
endpackage

// File: rtl/ctx_tlb_prio.sv
// Lowest-index priority encoder.
// Assumes N >= 1 and IW wide enough to hold N-1; idx is 0 when nothing is set.
module ctx_tlb_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ctx_tlb_match.sv
// Parallel key compare against every entry of the array.
// Assumes the caller supplies the valid bits; use_ctx=0 compares the page only.
module ctx_tlb_match #(
    parameter int DEPTH = 4,
    parameter int VPN_W = 36,
    parameter int CTX_W = 12
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][VPN_W-1:0] vpn_arr,
    input  logic [DEPTH-1:0][CTX_W-1:0] ctx_arr,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [CTX_W-1:0]            key_ctx,
    input  logic                        use_ctx,
    output logic [DEPTH-1:0]            hit_vec
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        // One comparator per entry.
        assign hit_vec[g] = valid[g] && (vpn_arr[g] == key_vpn) &&
                            (!use_ctx || (ctx_arr[g] == key_ctx));
    end
endmodule

// File: rtl/ctx_tlb_rr.sv
// Round-robin replacement pointer.
// Assumes DEPTH >= 2; it steps only when the top reports an eviction.
module ctx_tlb_rr #(
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // Advance with wrap after each replacement of a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/ctx_tlb.sv
// Fully associative translation buffer with context-tagged entries.
// Lookup is combinational. Fill, flush and context kill take effect at the
// next clock edge. Any invalidation discards a fill in the same cycle.
// Assumes DEPTH >= 2.
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int VPN_W = VPN_W_DEF,
    parameter int PFN_W = PFN_W_DEF,
    parameter int FLG_W = FLG_W_DEF,
    parameter int CTX_W = CTX_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_en,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [CTX_W-1:0] lk_ctx,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [FLG_W-1:0] lk_flags,
    input  logic             fl_valid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [CTX_W-1:0] fl_ctx,
    input  logic [PFN_W-1:0] fl_pfn,
    input  logic [FLG_W-1:0] fl_flags,
    input  logic             root_wr,
    input  logic             ctx_kill,
    input  logic [CTX_W-1:0] kill_ctx
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0][VPN_W-1:0] vpn_q;
    logic [DEPTH-1:0][CTX_W-1:0] ctx_q;
    logic [DEPTH-1:0][PFN_W-1:0] pfn_q;
    logic [DEPTH-1:0][FLG_W-1:0] flg_q;

    logic [DEPTH-1:0] lk_vec, fl_vec, kill_vec;
    logic             lk_any, fl_hit_any, free_any;
    logic [IDX_W-1:0] lk_idx, fl_hit_idx, free_idx, rr_ptr, tgt_idx;
    logic             flush_all, fill_go, evict;
    fill_src_e        fill_src;

    ctx_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lk_match (
        .valid(valid_q), .vpn_arr(vpn_q), .ctx_arr(ctx_q),
        .key_vpn(lk_vpn), .key_ctx(lk_ctx), .use_ctx(tag_en), .hit_vec(lk_vec)
    );

    ctx_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fl_match (
        .valid(valid_q), .vpn_arr(vpn_q), .ctx_arr(ctx_q),
        .key_vpn(fl_vpn), .key_ctx(fl_ctx), .use_ctx(tag_en), .hit_vec(fl_vec)
    );

    ctx_tlb_prio #(.N(DEPTH), .IW(IDX_W)) u_lk_prio (
        .req(lk_vec), .any(lk_any), .idx(lk_idx)
    );

    ctx_tlb_prio #(.N(DEPTH), .IW(IDX_W)) u_fl_prio (
        .req(fl_vec), .any(fl_hit_any), .idx(fl_hit_idx)
    );

    ctx_tlb_prio #(.N(DEPTH), .IW(IDX_W)) u_free_prio (
        .req(~valid_q), .any(free_any), .idx(free_idx)
    );

    ctx_tlb_rr #(.DEPTH(DEPTH), .IW(IDX_W)) u_rr (
        .clk(clk), .rst_n(rst_n), .step(evict), .ptr(rr_ptr)
    );

    // Per-entry hit on the context named by a kill request.
    for (genvar g = 0; g < DEPTH; g++) begin : g_kill
        assign kill_vec[g] = valid_q[g] && (ctx_q[g] == kill_ctx);
    end

    assign flush_all = root_wr && !tag_en;
    assign fill_go   = fl_valid && !flush_all && !ctx_kill;
    assign evict     = (fill_src == FILL_EVICT);

    // Choose the fill target: existing match, then free slot, then victim.
    always_comb begin
        fill_src = FILL_NONE;
        tgt_idx  = rr_ptr;
        if (fill_go) begin
            if (fl_hit_any) begin
                fill_src = FILL_HIT;
                tgt_idx  = fl_hit_idx;
            end else if (free_any) begin
                fill_src = FILL_FREE;
                tgt_idx  = free_idx;
            end else begin
                fill_src = FILL_EVICT;
            end
        end
    end

    // Valid bits: reset and flush clear all, kill clears one context, fill sets one.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid_q <= '0;
        else if (flush_all) valid_q <= '0;
        else if (ctx_kill)  valid_q <= valid_q & ~kill_vec;
        else if (fill_go)   valid_q[tgt_idx] <= 1'b1;
    end

    // Entry payload: written on an accepted fill, never reset.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            vpn_q[tgt_idx] <= fl_vpn;
            ctx_q[tgt_idx] <= fl_ctx;
            pfn_q[tgt_idx] <= fl_pfn;
            flg_q[tgt_idx] <= fl_flags;
        end
    end

    // Lookup result: stored fields on a hit, zero on a miss.
    always_comb begin
        lk_hit   = lk_any;
        lk_pfn   = lk_any ? pfn_q[lk_idx] : '0;
        lk_flags = lk_any ? flg_q[lk_idx] : '0;
    end
endmodule

// File: rtl/ctx_tlb_chk.sv
// Temporal checks on the TLB, bound into every instance of ctx_tlb.
// Assumes DEPTH >= 2 so that an eviction always moves the pointer.
module ctx_tlb_chk #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int PFN_W = 40,
    parameter int FLG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tag_en,
    input logic             root_wr,
    input logic             ctx_kill,
    input logic             fl_valid,
    input logic             lk_hit,
    input logic [PFN_W-1:0] lk_pfn,
    input logic [FLG_W-1:0] lk_flags,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] kill_vec,
    input logic             fl_hit_any,
    input logic             fill_go,
    input logic             evict,
    input logic [IDX_W-1:0] rr_ptr
);
    // R1: the cycle after reset, no entry is valid.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R2: a miss drives zero on frame and flags.
    a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pfn == '0 && lk_flags == '0));

    // R6: a root write without tagging empties the buffer.
    a_r6_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && !tag_en) |=> (valid_q == '0));

    // R6: a root write with tagging on changes nothing by itself.
    a_r6_tagged_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && tag_en && !ctx_kill && !fl_valid) |=> (valid_q == $past(valid_q)));

    // R9: entries of the killed context are gone next cycle.
    a_r9_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_kill |=> ((valid_q & $past(kill_vec)) == '0));

    // R10: a fill beside an invalidation adds no valid entry.
    a_r10_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && (ctx_kill || (root_wr && !tag_en)))
        |=> ($countones(valid_q) <= $countones($past(valid_q))));

    // R8: an overwrite keeps the number of valid entries.
    a_r8_overwrite_count: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && fl_hit_any) |=> ($countones(valid_q) == $countones($past(valid_q))));

    // R7: each eviction moves the replacement pointer.
    a_r7_rr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        evict |=> (rr_ptr != $past(rr_ptr)));
endmodule

bind ctx_tlb ctx_tlb_chk #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .PFN_W(PFN_W), .FLG_W(FLG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .root_wr(root_wr),
    .ctx_kill(ctx_kill), .fl_valid(fl_valid), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_flags(lk_flags), .valid_q(valid_q),
    .kill_vec(kill_vec), .fl_hit_any(fl_hit_any), .fill_go(fill_go),
    .evict(evict), .rr_ptr(rr_ptr)
);

// File: tb/tb_ctx_tlb.sv
// Scoreboard bench: driver tasks queue expected lookup results and a monitor
// compares them with the outputs 2 ns after the driving edge.
module tb_ctx_tlb;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tag_en = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic [11:0] lk_ctx = '0;
    logic        lk_hit;
    logic [39:0] lk_pfn;
    logic [7:0]  lk_flags;
    logic        fl_valid = 1'b0;
    logic [35:0] fl_vpn = '0;
    logic [11:0] fl_ctx = '0;
    logic [39:0] fl_pfn = '0;
    logic [7:0]  fl_flags = '0;
    logic        root_wr = 1'b0;
    logic        ctx_kill = 1'b0;
    logic [11:0] kill_ctx = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic        hit;
        logic [39:0] pfn;
        logic [7:0]  flg;
    } exp_t;
    exp_t sb[$];

    ctx_tlb #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .tag_en(tag_en),
        .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .lk_hit(lk_hit),
        .lk_pfn(lk_pfn), .lk_flags(lk_flags),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ctx(fl_ctx),
        .fl_pfn(fl_pfn), .fl_flags(fl_flags),
        .root_wr(root_wr), .ctx_kill(ctx_kill), .kill_ctx(kill_ctx)
    );

    always #5 clk = ~clk;

    // One idle cycle of control inputs.
    task automatic quiet();
        fl_valid = 1'b0;
        root_wr  = 1'b0;
        ctx_kill = 1'b0;
    endtask

    task automatic look(input string req, input logic [35:0] v, input logic [11:0] c,
                        input logic h, input logic [39:0] p, input logic [7:0] f);
        exp_t e;
        @(negedge clk);
        quiet();
        lk_vpn = v;
        lk_ctx = c;
        e.req = req; e.hit = h; e.pfn = h ? p : '0; e.flg = h ? f : '0;
        sb.push_back(e);
    endtask

    task automatic fill(input logic [35:0] v, input logic [11:0] c,
                        input logic [39:0] p, input logic [7:0] f);
        @(negedge clk);
        quiet();
        fl_valid = 1'b1; fl_vpn = v; fl_ctx = c; fl_pfn = p; fl_flags = f;
    endtask

    task automatic set_tag(input logic t);
        @(negedge clk);
        quiet();
        tag_en = t;
    endtask

    task automatic root_write();
        @(negedge clk);
        quiet();
        root_wr = 1'b1;
    endtask

    task automatic kill(input logic [11:0] c);
        @(negedge clk);
        quiet();
        ctx_kill = 1'b1;
        kill_ctx = c;
    endtask

    // Monitor: compare every queued expectation against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (lk_hit !== e.hit || lk_pfn !== e.pfn || lk_flags !== e.flg) begin
                    errors++;
                    $display("FAIL %s: hit=%0b pfn=%h flags=%h, expected hit=%0b pfn=%h flags=%h",
                             e.req, lk_hit, lk_pfn, lk_flags, e.hit, e.pfn, e.flg);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look("R1", 36'h0, 12'h0, 1'b0, '0, '0);
        look("R1", 36'h123, 12'h5, 1'b0, '0, '0);

        // R2/R3: tagged hit needs both fields; miss reads zero
        set_tag(1'b1);
        fill(36'd10, 12'd1, 40'h100, 8'h67);
        look("R2", 36'd10, 12'd1, 1'b1, 40'h100, 8'h67);
        look("R3", 36'd10, 12'd2, 1'b0, '0, '0);
        look("R2", 36'd11, 12'd1, 1'b0, '0, '0);

        // R4: same page under two contexts
        fill(36'd10, 12'd2, 40'h200, 8'h07);
        look("R4", 36'd10, 12'd1, 1'b1, 40'h100, 8'h67);
        look("R4", 36'd10, 12'd2, 1'b1, 40'h200, 8'h07);

        // R5: page-only match, lowest index (entry 0 holds context 1)
        set_tag(1'b0);
        look("R5", 36'd10, 12'd7, 1'b1, 40'h100, 8'h67);
        set_tag(1'b1);

        // R6: tagged root write keeps entries, untagged empties them
        root_write();
        look("R6", 36'd10, 12'd1, 1'b1, 40'h100, 8'h67);
        look("R6", 36'd10, 12'd2, 1'b1, 40'h200, 8'h07);
        set_tag(1'b0);
        root_write();
        set_tag(1'b1);
        look("R6", 36'd10, 12'd1, 1'b0, '0, '0);
        look("R6", 36'd10, 12'd2, 1'b0, '0, '0);

        // R9: kill one context only
        fill(36'd1, 12'd1, 40'h11, 8'h01);
        fill(36'd2, 12'd2, 40'h12, 8'h02);
        fill(36'd3, 12'd1, 40'h13, 8'h03);
        kill(12'd1);
        look("R9", 36'd1, 12'd1, 1'b0, '0, '0);
        look("R9", 36'd3, 12'd1, 1'b0, '0, '0);
        look("R9", 36'd2, 12'd2, 1'b1, 40'h12, 8'h02);

        // R10: fill beside a kill is discarded
        @(negedge clk);
        quiet();
        fl_valid = 1'b1; fl_vpn = 36'd4; fl_ctx = 12'd3; fl_pfn = 40'h14; fl_flags = 8'h04;
        ctx_kill = 1'b1; kill_ctx = 12'd2;
        look("R10", 36'd4, 12'd3, 1'b0, '0, '0);
        look("R10", 36'd2, 12'd2, 1'b0, '0, '0);
        // R10: fill beside a flushing root write is discarded
        set_tag(1'b0);
        @(negedge clk);
        quiet();
        fl_valid = 1'b1; fl_vpn = 36'd5; fl_ctx = 12'd3; fl_pfn = 40'h15; fl_flags = 8'h05;
        root_wr = 1'b1;
        set_tag(1'b1);
        look("R10", 36'd5, 12'd3, 1'b0, '0, '0);

        // R7/R11: four-entry instance, fill past capacity
        for (int i = 0; i < 4; i++) fill(36'(20 + i), 12'd0, 40'(32'h200 + i), 8'(i));
        fill(36'd24, 12'd0, 40'h204, 8'h04);       // evicts entry 0 (page 20)
        look("R7", 36'd20, 12'd0, 1'b0, '0, '0);
        look("R7", 36'd21, 12'd0, 1'b1, 40'h201, 8'h01);
        look("R11", 36'd24, 12'd0, 1'b1, 40'h204, 8'h04);
        fill(36'd25, 12'd0, 40'h205, 8'h05);       // evicts entry 1 (page 21)
        look("R7", 36'd21, 12'd0, 1'b0, '0, '0);
        look("R7", 36'd22, 12'd0, 1'b1, 40'h202, 8'h02);

        // R8: overwrite page 23 in place; the next eviction still takes entry 2
        fill(36'd23, 12'd0, 40'h299, 8'h99);
        look("R8", 36'd23, 12'd0, 1'b1, 40'h299, 8'h99);
        look("R8", 36'd22, 12'd0, 1'b1, 40'h202, 8'h02);
        fill(36'd26, 12'd0, 40'h206, 8'h06);
        look("R8", 36'd22, 12'd0, 1'b0, '0, '0);
        look("R8", 36'd23, 12'd0, 1'b1, 40'h299, 8'h99);
        look("R7", 36'd25, 12'd0, 1'b1, 40'h205, 8'h05);
        look("R7", 36'd26, 12'd0, 1'b1, 40'h206, 8'h06);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule